// File: doc/BRIEF.md
# Flash Erase and Write Guard

This block stands between the special-function-register write bus of an 8-bit CPU and an on-chip flash array. Software prepares an erase by loading a page number or setting a bulk-erase arm bit, and then writes a key byte to a command register. The block sends a one-cycle page-erase or bulk-erase strobe, with its address, to the flash, and reports busy until the flash answers with done. An arm is used up when its command is accepted, so every erase has to be prepared again.

Data-store cycles from the CPU normally go to data RAM. When the one-shot program-enable bit is set, the next store becomes a flash program pulse, and the bit then clears itself. Stores that come from the debug port always target flash. A security bit can only be set, and only a chip reset clears it. While it is set, page 0 can be neither erased nor programmed, debug stores are dropped, and the only debug action left is a bulk erase. A bulk erase also sends a clear pulse to data RAM. The security state is an output so that a companion debug block can read it.

Top module: `flash_guard`

## Requirements
- R1: After reset all strobes, `ram_we_o`, `busy_o` and `sec_o` are 0, both arms are clear and program-enable is 0.
- R2: Write the key 0x55 to the command register (address 0xC1) after a write to the page register (address 0xC2). If the block is not busy, one cycle later `fl_page_erase_o` pulses for exactly one cycle and `fl_addr_o` equals the page field shifted left by 9.
- R3: Write 0x03 or any value with bit 0 set to the control register (address 0xC3) to arm bulk erase. Then writing 0xAA to the command register while `dbg_en_i` is 1 and the block is idle gives a one-cycle `fl_mass_erase_o` pulse together with `ram_clear_o`. Without the arm, or with `dbg_en_i` at 0, the write does nothing.
- R4: A command value other than 0x55 or 0xAA has no effect and leaves the arms in place. An accepted command uses up its arm, so repeating the key without writing the page register or the control register again does nothing.
- R5: Bits 7:1 of the page register give flash address bits 15:9. Bit 0 is ignored.
- R6: `busy_o` rises in the cycle of any flash strobe and stays high until the cycle after `fl_done_i`. Erase commands and flash stores that arrive while it is high are dropped.
- R7: With program-enable set (control bit 1), the next CPU store (`st_dbg_i`=0) produces an `fl_prog_o` pulse carrying its address and data, and does not write RAM. Program-enable then clears, so the store after it goes to RAM.
- R8: With program-enable clear, a CPU store produces a one-cycle `ram_we_o` carrying its address and data, and no flash strobe.
- R9: A control write with bit 1 set is ignored for program-enable while `int_en_i` is 1. A control write with bit 1 clear clears program-enable.
- R10: Control bit 2 set makes `sec_o` 1 from the next cycle onward. Writing 0 there does not clear it. Only reset clears it.
- R11: While `sec_o` is 1, a page erase of page 0 is refused and its arm is kept. A CPU flash store to page 0 is dropped and does not write RAM, although it still clears program-enable. Other pages are not affected.
- R12: A debug store (`st_dbg_i`=1) programs flash only when `dbg_en_i` is 1 and `sec_o` is 0, whatever the state of program-enable. Bulk erase remains possible while `sec_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| int_en_i | input | 1 | Global interrupt enable of the CPU |
| dbg_en_i | input | 1 | Debug port enabled |
| st_valid_i | input | 1 | Data-store cycle |
| st_dbg_i | input | 1 | Store comes from the debug port |
| st_addr_i | input | 16 | Store address |
| st_data_i | input | 8 | Store data |
| fl_done_i | input | 1 | Flash operation finished |
| fl_page_erase_o | output | 1 | Page-erase strobe |
| fl_mass_erase_o | output | 1 | Bulk-erase strobe |
| fl_prog_o | output | 1 | Program strobe |
| fl_addr_o | output | 16 | Flash address for the strobe |
| fl_data_o | output | 8 | Program data |
| ram_we_o | output | 1 | Data RAM write |
| ram_addr_o | output | 16 | Data RAM address |
| ram_data_o | output | 8 | Data RAM write data |
| ram_clear_o | output | 1 | Data RAM clear pulse |
| busy_o | output | 1 | Flash operation pending |
| sec_o | output | 1 | Security state |

## Verification
The properties assume that a register write and a store never arrive in the same cycle. They also assume that `fl_done_i` is raised only while `busy_o` is high. The random stimulus therefore picks at most one bus action per cycle and pulses done only while the bench's own model shows the block busy. The security bit is set only rarely, so that most of the run exercises the unsecured paths, and periodic resets bring the block back to the unsecured state.

// File: rtl/flg_pkg.sv
package flg_pkg;
  // control register bit positions (software-visible layout)
  localparam int unsigned CTL_MASS_ARM = 0;
  localparam int unsigned CTL_PROG_EN  = 1;
  localparam int unsigned CTL_SECURE   = 2;
  // default register map and command keys
  localparam logic [7:0] REG_CMD  = 8'hC1;
  localparam logic [7:0] REG_PAGE = 8'hC2;
  localparam logic [7:0] REG_CTL  = 8'hC3;
  localparam logic [7:0] KEY_PAGE = 8'h55;
  localparam logic [7:0] KEY_MASS = 8'hAA;
endpackage

// File: rtl/flg_regs.sv
module flg_regs #(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PG_W   = 7,
  parameter logic [SFR_AW-1:0] PAGE_REG = flg_pkg::REG_PAGE,
  parameter logic [SFR_AW-1:0] CTL_REG  = flg_pkg::REG_CTL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              int_en,
  input  logic              page_take,
  input  logic              mass_take,
  input  logic              pwe_take,
  output logic [PG_W-1:0]   page_q,
  output logic              page_arm_q,
  output logic              mass_arm_q,
  output logic              pwe_q,
  output logic              sec_q
);
  import flg_pkg::*;

  logic            page_en, ctl_en;
  logic [PG_W-1:0] page_d;
  logic            page_arm_d, mass_arm_d, pwe_d, sec_d;

  always_comb begin
    page_en    = sfr_wr && (sfr_addr == PAGE_REG);
    ctl_en     = sfr_wr && (sfr_addr == CTL_REG);
    page_d     = sfr_wdata[DATA_W-1 -: PG_W];
    page_arm_d = page_arm_q;
    mass_arm_d = mass_arm_q;
    pwe_d      = pwe_q;
    sec_d      = sec_q;
    if (page_en)        page_arm_d = 1'b1;
    else if (page_take) page_arm_d = 1'b0;
    if (ctl_en) begin
      mass_arm_d = sfr_wdata[CTL_MASS_ARM];
      if (!sfr_wdata[CTL_PROG_EN]) pwe_d = 1'b0;
      else if (!int_en)            pwe_d = 1'b1;
      if (sfr_wdata[CTL_SECURE])   sec_d = 1'b1;
    end else begin
      if (mass_take) mass_arm_d = 1'b0;
      if (pwe_take)  pwe_d      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      page_arm_q <= 1'b0;
      mass_arm_q <= 1'b0;
      pwe_q      <= 1'b0;
      sec_q      <= 1'b0;
    end else begin
      if (page_en) page_q <= page_d;
      page_arm_q <= page_arm_d;
      mass_arm_q <= mass_arm_d;
      pwe_q      <= pwe_d;
      sec_q      <= sec_d;
    end
  end
endmodule

// File: rtl/flg_cmd.sv
module flg_cmd #(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PG_W   = 7,
  parameter logic [SFR_AW-1:0] CMD_REG  = flg_pkg::REG_CMD,
  parameter logic [DATA_W-1:0] PAGE_KEY = flg_pkg::KEY_PAGE,
  parameter logic [DATA_W-1:0] MASS_KEY = flg_pkg::KEY_MASS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [PG_W-1:0]   page,
  input  logic              page_arm,
  input  logic              mass_arm,
  input  logic              sec,
  input  logic              dbg_en,
  input  logic              prog_go,
  input  logic              done,
  output logic              page_go,
  output logic              mass_go,
  output logic              erase_go,
  output logic              page_stb_q,
  output logic              mass_stb_q,
  output logic              busy_q,
  output logic [ADDR_W-1:0] er_addr_q
);
  localparam int unsigned OFS_W = ADDR_W - PG_W;

  logic              cmd_wr, page0_locked, busy_d;
  logic [ADDR_W-1:0] er_addr_d;

  always_comb begin
    cmd_wr       = sfr_wr && (sfr_addr == CMD_REG);
    page0_locked = sec && (page == '0);
    page_go      = cmd_wr && (sfr_wdata == PAGE_KEY) && page_arm && !busy_q && !page0_locked;
    mass_go      = cmd_wr && (sfr_wdata == MASS_KEY) && mass_arm && dbg_en && !busy_q;
    erase_go     = page_go || mass_go;
    er_addr_d    = page_go ? {page, {OFS_W{1'b0}}} : '0;
    if (busy_q) busy_d = !done;
    else        busy_d = erase_go || prog_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_stb_q <= 1'b0;
      mass_stb_q <= 1'b0;
      busy_q     <= 1'b0;
      er_addr_q  <= '0;
    end else begin
      page_stb_q <= page_go;
      mass_stb_q <= mass_go;
      busy_q     <= busy_d;
      if (erase_go) er_addr_q <= er_addr_d;
    end
  end
endmodule

// File: rtl/flg_steer.sv
module flg_steer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PG_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              st_dbg,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              pwe,
  input  logic              sec,
  input  logic              dbg_en,
  input  logic              busy,
  input  logic              erase_go,
  output logic              prog_go,
  output logic              pwe_take,
  output logic              prog_stb_q,
  output logic [ADDR_W-1:0] prog_addr_q,
  output logic [DATA_W-1:0] prog_data_q,
  output logic              ram_we_q,
  output logic [ADDR_W-1:0] ram_addr_q,
  output logic [DATA_W-1:0] ram_data_q
);
  logic cpu_st, cpu_flash, cpu_ram, hits_page0, cpu_ok, dbg_ok;

  always_comb begin
    cpu_st     = st_valid && !st_dbg;
    cpu_flash  = cpu_st && pwe;
    cpu_ram    = cpu_st && !pwe;
    hits_page0 = (st_addr[ADDR_W-1 -: PG_W] == '0);
    cpu_ok     = cpu_flash && !(sec && hits_page0);
    dbg_ok     = st_valid && st_dbg && dbg_en && !sec;
    prog_go    = (cpu_ok || dbg_ok) && !busy && !erase_go;
    pwe_take   = cpu_flash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_stb_q  <= 1'b0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
      ram_we_q    <= 1'b0;
      ram_addr_q  <= '0;
      ram_data_q  <= '0;
    end else begin
      prog_stb_q <= prog_go;
      ram_we_q   <= cpu_ram;
      if (prog_go) begin
        prog_addr_q <= st_addr;
        prog_data_q <= st_data;
      end
      if (cpu_ram) begin
        ram_addr_q <= st_addr;
        ram_data_q <= st_data;
      end
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PG_W   = 7,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr_i,
  input  logic [SFR_AW-1:0] sfr_addr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  input  logic              int_en_i,
  input  logic              dbg_en_i,
  input  logic              st_valid_i,
  input  logic              st_dbg_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              fl_done_i,
  output logic              fl_page_erase_o,
  output logic              fl_mass_erase_o,
  output logic              fl_prog_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_data_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              ram_clear_o,
  output logic              busy_o,
  output logic              sec_o
);
  logic [RST_SYNC-1:0] rst_pipe_q;
  logic                rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RST_SYNC-1];

  logic [PG_W-1:0]   page;
  logic              page_arm, mass_arm, pwe, sec;
  logic              page_go, mass_go, erase_go, prog_go, pwe_take;
  logic              page_stb, mass_stb, prog_stb, busy;
  logic [ADDR_W-1:0] er_addr, prog_addr;
  logic [DATA_W-1:0] prog_data;

  flg_regs #(.SFR_AW(SFR_AW), .DATA_W(DATA_W), .PG_W(PG_W)) regs_i (
    .clk(clk), .rst_n(rst_s_n),
    .sfr_wr(sfr_wr_i), .sfr_addr(sfr_addr_i), .sfr_wdata(sfr_wdata_i),
    .int_en(int_en_i), .page_take(page_go), .mass_take(mass_go), .pwe_take(pwe_take),
    .page_q(page), .page_arm_q(page_arm), .mass_arm_q(mass_arm), .pwe_q(pwe), .sec_q(sec)
  );

  flg_cmd #(.SFR_AW(SFR_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PG_W(PG_W)) cmd_i (
    .clk(clk), .rst_n(rst_s_n),
    .sfr_wr(sfr_wr_i), .sfr_addr(sfr_addr_i), .sfr_wdata(sfr_wdata_i),
    .page(page), .page_arm(page_arm), .mass_arm(mass_arm), .sec(sec),
    .dbg_en(dbg_en_i), .prog_go(prog_go), .done(fl_done_i),
    .page_go(page_go), .mass_go(mass_go), .erase_go(erase_go),
    .page_stb_q(page_stb), .mass_stb_q(mass_stb), .busy_q(busy), .er_addr_q(er_addr)
  );

  flg_steer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PG_W(PG_W)) steer_i (
    .clk(clk), .rst_n(rst_s_n),
    .st_valid(st_valid_i), .st_dbg(st_dbg_i), .st_addr(st_addr_i), .st_data(st_data_i),
    .pwe(pwe), .sec(sec), .dbg_en(dbg_en_i), .busy(busy), .erase_go(erase_go),
    .prog_go(prog_go), .pwe_take(pwe_take),
    .prog_stb_q(prog_stb), .prog_addr_q(prog_addr), .prog_data_q(prog_data),
    .ram_we_q(ram_we_o), .ram_addr_q(ram_addr_o), .ram_data_q(ram_data_o)
  );

  assign fl_page_erase_o = page_stb;
  assign fl_mass_erase_o = mass_stb;
  assign ram_clear_o     = mass_stb;
  assign fl_prog_o       = prog_stb;
  assign fl_addr_o       = prog_stb ? prog_addr : er_addr;
  assign fl_data_o       = prog_data;
  assign busy_o          = busy;
  assign sec_o           = sec;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PG_W   = 7
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              sfr_wr_i,
  input logic [SFR_AW-1:0] sfr_addr_i,
  input logic [DATA_W-1:0] sfr_wdata_i,
  input logic              fl_done_i,
  input logic              fl_page_erase_o,
  input logic              fl_mass_erase_o,
  input logic              fl_prog_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic              ram_we_o,
  input logic              ram_clear_o,
  input logic              busy_o,
  input logic              sec_o
);
  import flg_pkg::*;

  AST_MASS_CLEARS_RAM: assert property (@(posedge clk) disable iff (!rst_s_n)
    fl_mass_erase_o |-> ram_clear_o); // R3
  AST_MASS_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_s_n)
    fl_mass_erase_o |-> $past(sfr_wr_i && sfr_addr_i == REG_CMD && sfr_wdata_i == KEY_MASS)); // R3
  AST_PAGE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_s_n)
    fl_page_erase_o |-> $past(sfr_wr_i && sfr_addr_i == REG_CMD && sfr_wdata_i == KEY_PAGE)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({fl_page_erase_o, fl_mass_erase_o, fl_prog_o})); // R6
  AST_BUSY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fl_page_erase_o || fl_mass_erase_o || fl_prog_o) |-> busy_o); // R6
  AST_NO_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && !fl_done_i) |=> !(fl_page_erase_o || fl_mass_erase_o || fl_prog_o)); // R6
  AST_RAM_OR_FLASH: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(ram_we_o && fl_prog_o)); // R7
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    sec_o |=> sec_o); // R10
  AST_PAGE0_GUARD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fl_page_erase_o && $past(sec_o)) |-> (fl_addr_o[ADDR_W-1 -: PG_W] != '0)); // R11
endmodule

bind flash_guard flash_guard_chk #(.SFR_AW(SFR_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PG_W(PG_W)) chk_i (
  .clk(clk), .rst_s_n(rst_s_n),
  .sfr_wr_i(sfr_wr_i), .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
  .fl_done_i(fl_done_i),
  .fl_page_erase_o(fl_page_erase_o), .fl_mass_erase_o(fl_mass_erase_o),
  .fl_prog_o(fl_prog_o), .fl_addr_o(fl_addr_o),
  .ram_we_o(ram_we_o), .ram_clear_o(ram_clear_o),
  .busy_o(busy_o), .sec_o(sec_o)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  localparam logic [7:0] A_CMD = 8'hC1, A_PAGE = 8'hC2, A_CTL = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sfr_wr = 0, int_en = 0, dbg_en = 0, st_valid = 0, st_dbg = 0, done = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, st_data = 0;
  logic [15:0] st_addr = 0;
  logic pg_o, ms_o, pr_o, rwe_o, rclr_o, busy_o, sec_o;
  logic [15:0] fa_o, ra_o;
  logic [7:0] fd_o, rd_o;

  always #4 clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_wr_i(sfr_wr), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
    .int_en_i(int_en), .dbg_en_i(dbg_en), .st_valid_i(st_valid), .st_dbg_i(st_dbg),
    .st_addr_i(st_addr), .st_data_i(st_data), .fl_done_i(done),
    .fl_page_erase_o(pg_o), .fl_mass_erase_o(ms_o), .fl_prog_o(pr_o), .fl_addr_o(fa_o),
    .fl_data_o(fd_o), .ram_we_o(rwe_o), .ram_addr_o(ra_o), .ram_data_o(rd_o),
    .ram_clear_o(rclr_o), .busy_o(busy_o), .sec_o(sec_o)
  );

  int n_chk = 0, n_fail = 0;
  // bench model of the block state
  logic [6:0] m_page; logic m_parm, m_marm, m_pwe, m_sec, m_busy;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_page = 0; m_parm = 0; m_marm = 0; m_pwe = 0; m_sec = 0; m_busy = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sfr_wr = 0; st_valid = 0; done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  // drive one cycle at a falling edge, compare at the next falling edge
  task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] d,
                      input bit st, input bit sdbg, input logic [15:0] sa, input logic [7:0] sd,
                      input bit ie, input bit de, input bit dn, input string tag);
    bit cmd, e_pg, e_ms, e_eg, cpu_fl, e_pr, e_rw, e_busy;
    logic [15:0] e_fa;
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d; st_valid = st; st_dbg = sdbg;
    st_addr = sa; st_data = sd; int_en = ie; dbg_en = de; done = dn;
    cmd    = wr && a == A_CMD;
    e_pg   = cmd && d == 8'h55 && m_parm && !m_busy && !(m_sec && m_page == 0);
    e_ms   = cmd && d == 8'hAA && m_marm && de && !m_busy;
    e_eg   = e_pg || e_ms;
    cpu_fl = st && !sdbg && m_pwe;
    e_rw   = st && !sdbg && !m_pwe;
    e_pr   = !m_busy && !e_eg &&
             ((cpu_fl && !(m_sec && sa[15:9] == 0)) || (st && sdbg && de && !m_sec));
    e_busy = m_busy ? !dn : (e_eg || e_pr);
    e_fa   = e_pr ? sa : (e_pg ? {m_page, 9'h0} : 16'h0);
    if (wr && a == A_PAGE) begin m_page = d[7:1]; m_parm = 1; end
    else if (e_pg) m_parm = 0;
    if (wr && a == A_CTL) begin
      m_marm = d[0];
      if (!d[1]) m_pwe = 0; else if (!ie) m_pwe = 1;
      if (d[2]) m_sec = 1;
    end else begin
      if (e_ms) m_marm = 0;
      if (cpu_fl) m_pwe = 0;
    end
    m_busy = e_busy;
    @(negedge clk);
    check(pg_o === e_pg, tag, "page_erase", pg_o, e_pg);
    check(ms_o === e_ms && rclr_o === e_ms, tag, "mass_erase/ram_clear", {ms_o, rclr_o}, {e_ms, e_ms});
    check(pr_o === e_pr, tag, "prog", pr_o, e_pr);
    check(rwe_o === e_rw, tag, "ram_we", rwe_o, e_rw);
    check(busy_o === e_busy, tag, "busy", busy_o, e_busy);
    check(sec_o === m_sec, tag, "sec", sec_o, m_sec);
    if (e_pg || e_ms || e_pr) check(fa_o === e_fa, tag, "fl_addr", fa_o, e_fa);
    if (e_pr) check(fd_o === sd, tag, "fl_data", fd_o, sd);
    if (e_rw) check(ra_o === sa && rd_o === sd, tag, "ram addr/data", {ra_o, rd_o}, {sa, sd});
    sfr_wr = 0; st_valid = 0; done = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input bit ie, input bit de, input string tag);
    step(1, a, d, 0, 0, 0, 0, ie, de, 0, tag);
  endtask
  task automatic store(input bit sdbg, input logic [15:0] sa, input logic [7:0] sd, input bit ie, input bit de, input string tag);
    step(0, 0, 0, 1, sdbg, sa, sd, ie, de, 0, tag);
  endtask
  task automatic finish_op(input bit de, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, de, 1, tag);
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({pg_o, ms_o, pr_o, rwe_o, rclr_o, busy_o, sec_o} === 7'b0, "R1", "reset outputs",
          {pg_o, ms_o, pr_o, rwe_o, rclr_o, busy_o, sec_o}, 0);
    // R2 / R5 page erase, bit 0 ignored
    wr_reg(A_PAGE, 8'h07, 0, 0, "R5");
    wr_reg(A_CMD, 8'h55, 0, 0, "R2");
    wr_reg(A_PAGE, 8'h08, 0, 0, "R6");
    wr_reg(A_CMD, 8'h55, 0, 0, "R6");   // dropped while busy
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    finish_op(0, "R6");
    wr_reg(A_CMD, 8'h55, 0, 0, "R2");   // arm kept since the busy attempt was dropped
    finish_op(0, "R6");
    wr_reg(A_CMD, 8'h55, 0, 0, "R4");   // arm used up
    // R4 wrong key keeps the arm
    wr_reg(A_PAGE, 8'hFE, 0, 0, "R4");
    wr_reg(A_CMD, 8'h12, 0, 0, "R4");
    wr_reg(A_CMD, 8'h55, 0, 0, "R4");
    finish_op(0, "R6");
    // R3 bulk erase gating
    wr_reg(A_CMD, 8'hAA, 0, 1, "R3");   // no arm
    wr_reg(A_CTL, 8'h01, 0, 0, "R3");
    wr_reg(A_CMD, 8'hAA, 0, 0, "R3");   // debug disabled
    wr_reg(A_CMD, 8'hAA, 0, 1, "R3");
    finish_op(1, "R3");
    wr_reg(A_CMD, 8'hAA, 0, 1, "R4");
    // R7 / R8 program enable one-shot
    wr_reg(A_CTL, 8'h02, 0, 0, "R7");
    store(0, 16'h1234, 8'h5A, 0, 0, "R7");
    finish_op(0, "R7");
    store(0, 16'h1235, 8'hA5, 0, 0, "R8");
    // R9 enable ignored with interrupts on, then cleared by a zero write
    wr_reg(A_CTL, 8'h02, 1, 0, "R9");
    store(0, 16'h2000, 8'h11, 1, 0, "R9");
    wr_reg(A_CTL, 8'h02, 0, 0, "R9");
    wr_reg(A_CTL, 8'h02, 1, 0, "R9");   // keeps enable
    store(0, 16'h2001, 8'h22, 0, 0, "R9");
    finish_op(0, "R9");
    wr_reg(A_CTL, 8'h02, 0, 0, "R9");
    wr_reg(A_CTL, 8'h00, 0, 0, "R9");
    store(0, 16'h2002, 8'h33, 0, 0, "R9");
    // R12 debug store unsecured
    store(1, 16'h0100, 8'h44, 0, 1, "R12");
    finish_op(1, "R12");
    store(1, 16'h0101, 8'h45, 0, 0, "R12");
    // R10 security sticky
    wr_reg(A_CTL, 8'h04, 0, 0, "R10");
    wr_reg(A_CTL, 8'h00, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R11 page 0 guard
    wr_reg(A_PAGE, 8'h01, 0, 0, "R11");
    wr_reg(A_CMD, 8'h55, 0, 0, "R11");
    wr_reg(A_PAGE, 8'h02, 0, 0, "R11");
    wr_reg(A_CMD, 8'h55, 0, 0, "R11");
    finish_op(0, "R11");
    wr_reg(A_CTL, 8'h02, 0, 0, "R11");
    store(0, 16'h0010, 8'h66, 0, 0, "R11");
    store(0, 16'h0011, 8'h67, 0, 0, "R11");
    wr_reg(A_CTL, 8'h02, 0, 0, "R11");
    store(0, 16'h0210, 8'h68, 0, 0, "R11");
    finish_op(0, "R11");
    // R12 secured: debug stores dropped, bulk erase allowed
    store(1, 16'h4000, 8'h77, 0, 1, "R12");
    wr_reg(A_CTL, 8'h01, 0, 1, "R12");
    wr_reg(A_CMD, 8'hAA, 0, 1, "R12");
    finish_op(1, "R12");
    // random phase
    void'($urandom(32'd1209));
    for (int i = 0; i < 6000; i++) begin
      int unsigned op = $urandom_range(0, 15);
      bit ie = ($urandom_range(0, 3) == 0);
      bit de = ($urandom_range(0, 3) != 0);
      logic [15:0] sa = {$urandom_range(0, 1) ? 7'h0 : 7'($urandom), 9'($urandom)};
      logic [7:0] sd = 8'($urandom);
      if (i % 1500 == 0) do_reset();
      if (m_busy && op < 4)
        step(0, 0, 0, 0, 0, 0, 0, ie, de, 1, "R6");
      else if (op < 6)
        wr_reg(A_PAGE, 8'($urandom), ie, de, "R2");
      else if (op < 8) begin
        logic [7:0] c = 8'($urandom) & 8'h03;
        if ($urandom_range(0, 40) == 0) c = c | 8'h04;
        wr_reg(A_CTL, c, ie, de, "R9");
      end else if (op < 11) begin
        int unsigned k = $urandom_range(0, 2);
        wr_reg(A_CMD, k == 0 ? 8'h55 : (k == 1 ? 8'hAA : 8'($urandom)), ie, de, "R3");
      end else if (op < 15)
        store($urandom_range(0, 3) == 0, sa, sd, ie, de, "R7");
      else
        step(0, 0, 0, 0, 0, 0, 0, ie, de, 0, "R8");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule